// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a clocked system read and write single bytes in an asynchronous byte-wide static RAM. It has a 19-bit word address. The user side offers a ready/valid handshake. A request is taken when `req_valid` is high on a clock edge where `req_ready` is high. The controller then drives the memory's address bus and its three active-low strobes (chip select, output enable, write enable). It also drives a split tri-state data bus, made of an output word, an input word and a driver enable. Each strobe is sequenced so that the memory's nanosecond minimums are met.

Every phase length is worked out at elaboration from the clock period parameter `CLK_PERIOD_NS` and the timing parameters. The rule is the ceiling of the minimum time divided by the period, and never less than one cycle. A read keeps chip select and output enable low for the access time. The byte on the bus is latched on the last access cycle and handed back with a one-cycle `rd_valid` pulse.

A write uses only write-enable control. Chip select falls first, then write enable is pulsed with the address and data held steady, and output enable stays high throughout. The controller turns its data drivers on only after the memory has had time to release the bus following the last read.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: An accepted read drives `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for exactly RD cycles, starting the cycle after acceptance. RD is the ceiling of max(read cycle time, access time) divided by the period, with a minimum of 1.
- R3: Read data is captured from `mem_dq_in` on the last read access cycle. In the next cycle all strobes are high, `rd_valid` is 1 for that single cycle, and `rd_data` holds the byte. `req_ready` returns to 1 in the cycle after that.
- R4: A write begins with SU setup cycles (minimum 1) in which `mem_cs_n`=0, `mem_oe_n`=1 and `mem_we_n`=1. During these cycles `mem_dq_oe`=1 and `mem_dq_out` carries the request's data.
- R5: After setup, `mem_we_n` is 0 for PW cycles. PW is the ceiling of max(write pulse, address-to-end-of-write, data-to-end-of-write) divided by the period. Then come HD hold cycles with `mem_we_n`=1 and chip select and drivers still on, where SU+PW+HD is at least the write cycle time in cycles. After that all strobes go high, drivers turn off and `req_ready` is 1.
- R6: While `mem_cs_n` is 0, `mem_addr` equals the address of the request being served and does not change.
- R7: When a write is accepted while the bus-release counter is still running, the controller first waits with all strobes high and drivers off. The counter is loaded with TURN (the ceiling of the release time) on the cycle output enable goes high after a read, and counts down once per cycle. The number of wait cycles equals the counter value at acceptance.
- R8: `mem_dq_oe` is 1 only while `mem_cs_n` is 0 and `mem_oe_n` is 1.
- R9: Requests presented while `req_ready` is 0 are ignored. They start no access and change no memory contents, and exactly one `rd_valid` pulse is produced per accepted read.
- R10: `mem_oe_n` and `mem_we_n` are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte sampled from the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |

## Verification
The hardest case to reach from the ports is a write accepted while the bus-release counter is still non-zero. This only happens when the release time is longer than one clock and a write follows a read as closely as the handshake allows. The bench therefore builds the controller with a 3 ns period setting, which gives a two-cycle turnaround. It then issues writes immediately after reads, both in directed pairs and in a random mix over a small set of addresses. A second hard case is a request held on the inputs while a transaction is in progress. It is covered by keeping `req_valid` high with a different address and operation during a read, and then reading back to show that nothing was written.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RETURN,
        ST_WR_WAIT,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } asram_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } asram_strobe_t;

    localparam asram_strobe_t STB_OFF      = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    localparam asram_strobe_t STB_READ     = '{cs_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
    localparam asram_strobe_t STB_WR_ARM   = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
    localparam asram_strobe_t STB_WR_PULSE = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};

    // Ceiling of ns / period, never below one cycle.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] length,
    output logic             done
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= length - CNT_W'(1);
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign done = (remain == '0);
endmodule

// File: rtl/asram_turn_guard.sv
module asram_turn_guard #(
    parameter int CNT_W    = 3,
    parameter int TURN_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic busy
);
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (arm) begin
            left <= CNT_W'(TURN_CYC);
        end else if (left != '0) begin
            left <= left - CNT_W'(1);
        end
    end

    assign busy = (left != '0);
endmodule

// File: rtl/asram_read_latch.sv
module asram_read_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) data <= bus_in;
        end
    end

    // R3: the valid flag is a single-cycle pulse
    a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_CYCLE_NS    = 12,
    parameter int T_ACCESS_NS   = 12,
    parameter int T_WPULSE_NS   = 8,
    parameter int T_ADDR_END_NS = 8,
    parameter int T_DATA_END_NS = 6,
    parameter int T_SETUP_NS    = 0,
    parameter int T_RECOVER_NS  = 0,
    parameter int T_DHOLD_NS    = 0,
    parameter int T_RELEASE_NS  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int unsigned RD_CYC   = ns_to_cycles(umax(T_CYCLE_NS, T_ACCESS_NS), CLK_PERIOD_NS);
    localparam int unsigned SU_CYC   = ns_to_cycles(T_SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned PW_CYC   = ns_to_cycles(umax(T_WPULSE_NS, umax(T_ADDR_END_NS, T_DATA_END_NS)),
                                                    CLK_PERIOD_NS);
    localparam int unsigned HD_MIN   = ns_to_cycles(umax(T_RECOVER_NS, T_DHOLD_NS), CLK_PERIOD_NS);
    localparam int unsigned WC_CYC   = ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned HD_CYC   = (SU_CYC + PW_CYC + HD_MIN >= WC_CYC) ? HD_MIN
                                                                           : WC_CYC - SU_CYC - PW_CYC;
    localparam int unsigned TURN_CYC = ns_to_cycles(T_RELEASE_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, SU_CYC), umax(umax(PW_CYC, HD_CYC), TURN_CYC));
    localparam int          CNT_W    = $clog2(MAX_CYC + 1);

    asram_state_e      state;
    asram_strobe_t     stb;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              ready_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic              tmr_done;
    logic              turn_busy;
    logic              rd_last;

    assign rd_last = (state == ST_RD_ACCESS) && tmr_done;

    // Phase length to load on each transition into a timed phase
    always_comb begin
        tmr_load = 1'b0;
        tmr_len  = CNT_W'(1);
        unique case (state)
            ST_IDLE: if (req_valid) begin
                if (!req_write) begin
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(RD_CYC);
                end else if (!turn_busy) begin
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(SU_CYC);
                end
            end
            ST_WR_WAIT: if (!turn_busy) begin
                tmr_load = 1'b1;
                tmr_len  = CNT_W'(SU_CYC);
            end
            ST_WR_SETUP: if (tmr_done) begin
                tmr_load = 1'b1;
                tmr_len  = CNT_W'(PW_CYC);
            end
            ST_WR_PULSE: if (tmr_done) begin
                tmr_load = 1'b1;
                tmr_len  = CNT_W'(HD_CYC);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            stb     <= STB_OFF;
            ready_q <= 1'b1;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    ready_q <= 1'b0;
                    if (!req_write) begin
                        state <= ST_RD_ACCESS;
                        stb   <= STB_READ;
                    end else if (turn_busy) begin
                        state <= ST_WR_WAIT;
                    end else begin
                        state <= ST_WR_SETUP;
                        stb   <= STB_WR_ARM;
                    end
                end
                ST_RD_ACCESS: if (tmr_done) begin
                    state <= ST_RD_RETURN;
                    stb   <= STB_OFF;
                end
                ST_RD_RETURN: begin
                    state   <= ST_IDLE;
                    ready_q <= 1'b1;
                end
                ST_WR_WAIT: if (!turn_busy) begin
                    state <= ST_WR_SETUP;
                    stb   <= STB_WR_ARM;
                end
                ST_WR_SETUP: if (tmr_done) begin
                    state <= ST_WR_PULSE;
                    stb   <= STB_WR_PULSE;
                end
                ST_WR_PULSE: if (tmr_done) begin
                    state <= ST_WR_HOLD;
                    stb   <= STB_WR_ARM;
                end
                ST_WR_HOLD: if (tmr_done) begin
                    state   <= ST_IDLE;
                    stb     <= STB_OFF;
                    ready_q <= 1'b1;
                end
                default: begin
                    state   <= ST_IDLE;
                    stb     <= STB_OFF;
                    ready_q <= 1'b1;
                end
            endcase
        end
    end

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .length (tmr_len),
        .done   (tmr_done)
    );

    asram_turn_guard #(.CNT_W(CNT_W), .TURN_CYC(TURN_CYC)) u_turn (
        .clk  (clk),
        .rst  (rst),
        .arm  (rd_last),
        .busy (turn_busy)
    );

    asram_read_latch #(.DATA_W(DATA_W)) u_rdlat (
        .clk     (clk),
        .rst     (rst),
        .capture (rd_last),
        .bus_in  (mem_dq_in),
        .data    (rd_data),
        .valid   (rd_valid)
    );

    assign req_ready  = ready_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_cs_n   = stb.cs_n;
    assign mem_oe_n   = stb.oe_n;
    assign mem_we_n   = stb.we_n;
    assign mem_dq_oe  = stb.drive;

    // Cycles since output enable was last low, saturating; checks the turnaround
    logic [CNT_W:0] oe_gap;
    always_ff @(posedge clk) begin
        if (rst)                 oe_gap <= '1;
        else if (!mem_oe_n)      oe_gap <= '0;
        else if (oe_gap != '1)   oe_gap <= oe_gap + 1'b1;
    end

    // R7: drivers turn on no sooner than the release window after a read
    a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (int'(oe_gap) >= int'(TURN_CYC)));

    // R8: drivers only inside a chip-selected cycle with output enable high
    a_r8_drive_window: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_cs_n && mem_oe_n));

    // R6: address frozen while chip select stays low
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    // R9: nothing is taken while not ready
    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(mem_addr));

    // R3: ready comes back right after the read pulse
    a_r3_ready_after_valid: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> req_ready);

    // R5: write enable low only inside chip select with data driven
    a_r5_we_framed: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_dq_oe));

    // R10: read and write enables never overlap
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));
endmodule

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;
    localparam int P  = 3;     // period setting given to the controller
    localparam int AW = 19;
    localparam int DW = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + P - 1) / P;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int B_RD   = cyc(12);
    localparam int B_SU   = cyc(0);
    localparam int B_PW   = cyc(8);
    localparam int B_HD   = (cyc(0) > cyc(12) - B_SU - B_PW) ? cyc(0) : cyc(12) - B_SU - B_PW;
    localparam int B_TURN = cyc(6);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hEE;

    always #4 clk = ~clk;

    asram_ctrl #(.CLK_PERIOD_NS(P)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // ---------------- behavioural memory on the bus ----------------
    logic [DW-1:0] cells [int];
    always @(negedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) cells[int'(mem_addr)] = mem_dq_out;
        if (!mem_cs_n && !mem_oe_n && mem_we_n)
            mem_dq_in <= cells.exists(int'(mem_addr)) ? cells[int'(mem_addr)] : init_val(mem_addr);
        else
            mem_dq_in <= 8'hEE;
    end

    // ---------------- reference model ----------------
    typedef struct {
        logic cs_n, oe_n, we_n, drv, rdy, rdv;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    logic [DW-1:0] ref_mem [int];
    int  turn_left = 0;
    int  t_before;
    int  reads_exp = 0;
    int  reads_seen = 0;
    bit  checking = 1'b0;

    function automatic exp_t mk(input logic cs, oe, we, drv, rdy, rdv, input string tag);
        exp_t e;
        e.cs_n = cs; e.oe_n = oe; e.we_n = we; e.drv = drv; e.rdy = rdy; e.rdv = rdv;
        e.addr = '0; e.data = '0; e.tag = tag;
        return e;
    endfunction

    task automatic build(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input int waits);
        exp_t e;
        if (!w) begin
            reads_exp++;
            for (int i = 0; i < B_RD; i++) begin
                e = mk(0, 0, 1, 0, 0, 0, "R2"); e.addr = a; q.push_back(e);
            end
            e = mk(1, 1, 1, 0, 0, 1, "R3");
            e.data = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
            q.push_back(e);
        end else begin
            for (int i = 0; i < waits; i++) q.push_back(mk(1, 1, 1, 0, 0, 0, "R7"));
            for (int i = 0; i < B_SU; i++) begin
                e = mk(0, 1, 1, 1, 0, 0, "R4"); e.addr = a; e.data = d; q.push_back(e);
            end
            for (int i = 0; i < B_PW; i++) begin
                e = mk(0, 1, 0, 1, 0, 0, "R5"); e.addr = a; e.data = d; q.push_back(e);
            end
            for (int i = 0; i < B_HD; i++) begin
                e = mk(0, 1, 1, 1, 0, 0, "R5"); e.addr = a; e.data = d; q.push_back(e);
            end
            ref_mem[int'(a)] = d;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur = mk(1, 1, 1, 0, 1, 0, "R1");
            turn_left = 0;
            checking = 1'b1;
        end else begin
            t_before = turn_left;
            if (cur.rdy && req_valid) build(req_write, req_addr, req_wdata, t_before);
            if (q.size() > 0) cur = q.pop_front();
            else              cur = mk(1, 1, 1, 0, 1, 0, "R9");
            if (cur.rdv)            turn_left = B_TURN;
            else if (turn_left > 0) turn_left--;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (checking) begin
            chk(cur.tag, "cs_n",   int'(mem_cs_n),  int'(cur.cs_n));
            chk(cur.tag, "oe_n",   int'(mem_oe_n),  int'(cur.oe_n));
            chk(cur.tag, "we_n",   int'(mem_we_n),  int'(cur.we_n));
            chk(cur.tag, "dq_oe",  int'(mem_dq_oe), int'(cur.drv));
            chk(cur.tag, "ready",  int'(req_ready), int'(cur.rdy));
            chk(cur.tag, "rd_valid", int'(rd_valid), int'(cur.rdv));
            if (cur.rdv)           chk("R3", "rd_data", int'(rd_data), int'(cur.data));
            if (!cur.cs_n)         chk("R6", "addr", int'(mem_addr), int'(cur.addr));
            if (cur.drv)           chk(cur.tag, "dq_out", int'(mem_dq_out), int'(cur.data));
            if (mem_dq_oe)         chk("R8", "drive window", int'(!mem_cs_n && mem_oe_n), 1);
            chk("R10", "oe/we overlap", int'(!mem_oe_n && !mem_we_n), 0);
            if (rd_valid && !rst)  reads_seen++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_req(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit junk);
        logic r;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        do begin
            r = req_ready;
            @(negedge clk);
        end while (!r);
        if (junk) begin
            // R9: keep a different request on the inputs while busy
            req_write = ~w; req_addr = a ^ 19'h1; req_wdata = ~d;
            repeat (2) @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            summary();
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1: idle after reset is compared by the per-cycle model
        do_req(0, 19'h00012, 8'h00, 0);          // R2/R3 untouched location
        do_req(1, 19'h00012, 8'hC3, 0);          // R7 write right after read
        do_req(0, 19'h00012, 8'h00, 0);
        do_req(1, 19'h7FFFF, 8'hFF, 0);          // R4/R5 top address
        do_req(1, 19'h00000, 8'h00, 0);          // back-to-back writes
        do_req(0, 19'h7FFFF, 8'h00, 0);
        do_req(0, 19'h00000, 8'h00, 0);
        do_req(0, 19'h00012, 8'h00, 1);          // R9 junk held while busy
        do_req(0, 19'h00013, 8'h00, 0);          // R9 neighbour not written
        repeat (6) @(negedge clk);
        do_req(1, 19'h00040, 8'h5A, 0);          // write with no pending turnaround
        for (int i = 0; i < 80; i++) begin
            logic [AW-1:0] a;
            a = {15'h0A5C, 4'($urandom_range(0, 15))};
            do_req(1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)), 0);
        end
        repeat (10) @(negedge clk);
        chk("R9", "read pulses", reads_seen, reads_exp);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule